// File: doc/BRIEF.md
# Zero-Substituting Bipolar Line Encoder

This block turns a serial transmit bit stream into the two rail signals of a bipolar line. Ones become marks of alternating polarity. Long runs of zeros are replaced by a code word that contains a bipolar violation, which keeps the line rich in transitions. A select input picks one of two codes at run time. The three-zero code (B3ZS) suits the 44.7 and 51.8 Mbit/s rates. The four-zero code (HDB3) suits the 34.4 Mbit/s rate.

A format input picks between two interfaces. In NRZ format the encoder is active. In rail format the two data inputs reach the rails unchanged, through the same four-stage pipeline, so the latency is the same in every setting. An all-ones request replaces the outgoing data with a continuous alternating-mark pattern. The data clock can sample the inputs on either of its edges. All internal state updates on the rising edge.

Top module: `bipolar_zs_encoder`

## Requirements
- R1: With `nrzMode`=1 and `b3zsSel`=1, a run of three zero bits is sent as 0,0,V or as B,0,V. After warm-up the rails never carry three consecutive spaces.
- R2: With `nrzMode`=1 and `b3zsSel`=0, a run of four zero bits is sent as 0,0,0,V or as B,0,0,V. After warm-up the rails never carry four consecutive spaces.
- R3: The bare form is used when the number of marks sent since the last V is odd. The B form is used when that number is even, and after reset it counts as even. B takes the polarity opposite to the previous mark. V repeats the polarity of the previous mark and restarts the count.
- R4: A one bit in NRZ format becomes a mark whose polarity is opposite to the previous mark.
- R5: The bit presented for sampling edge k reaches the rails just after rising edge k+4, in both codes and in both formats.
- R6: With `nrzMode`=0, `dataPos` and `dataNeg` appear unchanged on `railPos` and `railNeg`.
- R7: With `nrzMode`=1, `dataNeg` has no effect on the rails.
- R8: With `fallEdge`=0, the data inputs are sampled at the rising clock edge. With `fallEdge`=1 they are sampled at the falling edge that comes half a period before it.
- R9: While `allOnes` is high, the rails carry one mark per clock with alternating polarity, and the data inputs are ignored. Zero bits take their place in the pipeline.
- R10: While `rstN` is low at a rising edge, both rails go low and the pipeline is emptied. Empty stages send spaces and never trigger a substitution. The first mark after reset is positive.
- R11: In NRZ format the rails are never high at the same time. A positive mark is `railPos`=1, `railNeg`=0, and a negative mark is the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rstN | input | 1 | Synchronous reset, active low |
| fallEdge | input | 1 | 1: sample data on the falling edge; 0: sample on the rising edge |
| nrzMode | input | 1 | 1: NRZ format with encoding; 0: rail format passed through |
| b3zsSel | input | 1 | 1: three-zero code; 0: four-zero code |
| allOnes | input | 1 | Send the alternating all-ones pattern |
| dataPos | input | 1 | NRZ data, or positive rail data in rail format |
| dataNeg | input | 1 | Negative rail data in rail format; ignored in NRZ format |
| railPos | output | 1 | Positive rail of the line |
| railNeg | output | 1 | Negative rail of the line |

## Verification
The all-ones override and the zero substitution can act in the same cycle. This happens when the zero filler that the override pushes into the pipeline, or a zero run already in it, completes a substitution window while the override still owns the output. The B of that substitution is then lost, its V is still planted, and the override marks advance both the polarity and the count. To provoke this, bursts of `allOnes` are laid over sparse random NRZ data in both formats. Every rail value is then compared with a cycle-by-cycle model built from the requirements, including the polarity of the first V that comes out after each burst.

// File: rtl/zs_encoder_pkg.sv
package zs_encoder_pkg;

  // Content class of one pipeline stage
  typedef enum logic [1:0] {
    K_IDLE = 2'd0,   // emptied by reset: sends a space, blocks substitution
    K_ZERO = 2'd1,   // data zero
    K_ONE  = 2'd2,   // data one
    K_VIOL = 2'd3    // zero that was replaced by a violation
  } kind_t;

  typedef struct packed {
    kind_t kind;
    logic  p;        // rail format positive bit
    logic  n;        // rail format negative bit
  } stage_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic subst;     // zero window found: plant a violation
    logic shortRun;  // three-zero code selects the violation slot
    logic markOut;   // a mark goes on the line this cycle
    logic markPos;   // its polarity is positive
  } strobe_t;

endpackage

// File: rtl/zs_control.sv
module zs_control
  import zs_encoder_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  nrzMode,
  input  logic                  b3zsSel,
  input  logic                  allOnes,
  input  kind_t [DEPTH-1:0]     stageKinds,
  output strobe_t               stb
);

  logic  lastPos;    // polarity of the previous mark
  logic  oddMarks;   // parity of marks since the last violation
  logic  winZero;
  kind_t headKind;
  logic  headViol;
  logic  addBal;
  int    runLen;

  always_comb begin
    runLen  = b3zsSel ? B3ZS_RUN : HDB3_RUN;
    winZero = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (i >= DEPTH - runLen && stageKinds[i] != K_ZERO) winZero = 1'b0;
    end
  end

  assign headKind = stageKinds[DEPTH-1];
  assign headViol = (headKind == K_VIOL);
  assign addBal   = stb.subst && !oddMarks;

  always_comb begin
    stb.subst    = nrzMode && winZero;
    stb.shortRun = b3zsSel;
    stb.markOut  = allOnes ||
                   (nrzMode && (addBal || headKind == K_ONE || headViol));
    stb.markPos  = (headViol && !allOnes) ? lastPos : !lastPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPos  <= 1'b0;
      oddMarks <= 1'b0;
    end else if (stb.markOut) begin
      lastPos  <= stb.markPos;
      oddMarks <= (nrzMode && headViol && !allOnes) ? 1'b0 : !oddMarks;
    end
  end

endmodule

// File: rtl/zs_datapath.sv
module zs_datapath
  import zs_encoder_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fallEdge,
  input  logic              nrzMode,
  input  logic              allOnes,
  input  logic              dataPos,
  input  logic              dataNeg,
  input  strobe_t           stb,
  output kind_t [DEPTH-1:0] stageKinds,
  output logic              railPos,
  output logic              railNeg
);

  localparam int SLOT_LONG  = DEPTH - HDB3_RUN;
  localparam int SLOT_SHORT = DEPTH - B3ZS_RUN;

  logic   negPos, negNeg, smpPos, smpNeg;
  stage_t stg [DEPTH];
  stage_t nxt [DEPTH];
  int     vSlot;

  // Falling-edge capture, consumed at the following rising edge
  always_ff @(negedge clk) begin
    negPos <= dataPos;
    negNeg <= dataNeg;
  end

  assign smpPos = fallEdge ? negPos : dataPos;
  assign smpNeg = fallEdge ? negNeg : dataNeg;

  always_comb begin
    vSlot       = stb.shortRun ? SLOT_SHORT : SLOT_LONG;
    nxt[0].kind = (nrzMode && !allOnes && smpPos) ? K_ONE : K_ZERO;
    nxt[0].p    = !nrzMode && !allOnes && smpPos;
    nxt[0].n    = !nrzMode && !allOnes && smpNeg;
    for (int i = 1; i < DEPTH; i++) begin
      nxt[i] = stg[i-1];
      if (stb.subst && (i - 1) == vSlot) nxt[i].kind = K_VIOL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '{kind: K_IDLE, p: 1'b0, n: 1'b0};
      railPos <= 1'b0;
      railNeg <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= nxt[i];
      if (stb.markOut) begin
        railPos <= stb.markPos;
        railNeg <= !stb.markPos;
      end else if (!nrzMode) begin
        railPos <= stg[DEPTH-1].p;
        railNeg <= stg[DEPTH-1].n;
      end else begin
        railPos <= 1'b0;
        railNeg <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_kind
    assign stageKinds[g] = stg[g].kind;
  end

endmodule

// File: rtl/bipolar_zs_encoder.sv
module bipolar_zs_encoder
  import zs_encoder_pkg::*;
#(
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic fallEdge,
  input  logic nrzMode,
  input  logic b3zsSel,
  input  logic allOnes,
  input  logic dataPos,
  input  logic dataNeg,
  output logic railPos,
  output logic railNeg
);

  localparam int DEPTH = (HDB3_RUN > B3ZS_RUN) ? HDB3_RUN : B3ZS_RUN;

  strobe_t           stb;
  kind_t [DEPTH-1:0] stageKinds;

  zs_control #(.DEPTH(DEPTH), .HDB3_RUN(HDB3_RUN), .B3ZS_RUN(B3ZS_RUN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .nrzMode    (nrzMode),
    .b3zsSel    (b3zsSel),
    .allOnes    (allOnes),
    .stageKinds (stageKinds),
    .stb        (stb)
  );

  zs_datapath #(.DEPTH(DEPTH), .HDB3_RUN(HDB3_RUN), .B3ZS_RUN(B3ZS_RUN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fallEdge   (fallEdge),
    .nrzMode    (nrzMode),
    .allOnes    (allOnes),
    .dataPos    (dataPos),
    .dataNeg    (dataNeg),
    .stb        (stb),
    .stageKinds (stageKinds),
    .railPos    (railPos),
    .railNeg    (railNeg)
  );

endmodule

// File: rtl/zs_encoder_chk.sv
module zs_encoder_chk (
  input logic clk,
  input logic rstN,
  input logic nrzMode,
  input logic b3zsSel,
  input logic allOnes,
  input logic railPos,
  input logic railNeg
);

  logic       primed = 1'b0;
  logic       rstQ   = 1'b0;
  logic       aoQ1, aoQ2, cfgNrz, cfgB3;
  logic [3:0] warm;
  logic [2:0] spaceRun;

  always_ff @(posedge clk) begin
    primed <= 1'b1;
    rstQ   <= rstN;
    aoQ1   <= allOnes;
    aoQ2   <= aoQ1;
    cfgNrz <= nrzMode;
    cfgB3  <= b3zsSel;
    if (!rstN) begin
      warm     <= '0;
      spaceRun <= '0;
    end else begin
      if (nrzMode != cfgNrz || b3zsSel != cfgB3) warm <= '0;
      else if (warm != 4'hF)                     warm <= warm + 4'd1;
      if (railPos || railNeg)    spaceRun <= '0;
      else if (spaceRun != 3'd7) spaceRun <= spaceRun + 3'd1;
    end
  end

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    (primed && !rstQ) |-> (!railPos && !railNeg));

  // R11
  rails_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm > 4'd1 && cfgNrz) |-> !(railPos && railNeg));

  // R9
  ones_alternate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm > 4'd2 && aoQ1 && aoQ2) |-> ((railPos ^ railNeg) && railPos == $past(railNeg)));

  // R1 R2
  zero_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm > 4'd8 && cfgNrz) |-> (spaceRun < (cfgB3 ? 3'd3 : 3'd4)));

endmodule

bind bipolar_zs_encoder zs_encoder_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .nrzMode (nrzMode),
  .b3zsSel (b3zsSel),
  .allOnes (allOnes),
  .railPos (railPos),
  .railNeg (railNeg)
);

// File: tb/bipolar_zs_encoder_bench.sv
module bipolar_zs_encoder_bench;

  localparam int MAXN = 160;

  logic clk = 1'b0;
  logic rstN = 1'b0, fallEdge = 1'b0, nrzMode = 1'b1, b3zsSel = 1'b0;
  logic allOnes = 1'b0, dataPos = 1'b0, dataNeg = 1'b0;
  logic railPos, railNeg;

  int  checkCnt = 0, failCnt = 0;
  bit  finished = 1'b0;
  bit  dA [MAXN], nA [MAXN], aoA [MAXN];
  bit  actP [MAXN], actN [MAXN];

  always #5 clk = ~clk;

  bipolar_zs_encoder u_bipolar_zs_encoder (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .nrzMode(nrzMode),
    .b3zsSel(b3zsSel), .allOnes(allOnes), .dataPos(dataPos), .dataNeg(dataNeg),
    .railPos(railPos), .railNeg(railNeg)
  );

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  task automatic check(input string tag, input int c, input bit ap, an, ep, en);
    checkCnt++;
    if (ap !== ep || an !== en) begin
      failCnt++;
      $display("FAIL %s cycle %0d rails act=%b%b exp=%b%b", tag, c, ap, an, ep, en);
    end
  endtask

  function automatic bit effBit(input int j, input int nBits);
    if (j < 0 || j >= nBits) return 1'b0;
    return aoA[j] ? 1'b0 : dA[j];
  endfunction

  // Expected rails from the requirements, one entry per rising edge after reset
  task automatic judge(input string tag, input bit nrz, b3, input int nBits, nCyc);
    bit vt [MAXN + 8];
    bit lastPos = 1'b0, odd = 1'b0;
    int runLen = b3 ? 3 : 4;
    for (int k = 0; k < MAXN + 8; k++) vt[k] = 1'b0;
    for (int c = 0; c < nCyc; c++) begin
      int j = c - 4;
      bit ao = (c < nBits) ? aoA[c] : 1'b0;
      bit isV = 1'b0, isOne = 1'b0, bal = 1'b0, mark, ep, en;
      if (nrz) begin
        bit win = 1'b1;
        if (j >= 0) begin
          isV   = vt[j];
          isOne = !vt[j] && effBit(j, nBits);
        end
        for (int k = 0; k < runLen; k++) begin
          if (j + k < 0 || vt[j+k] || effBit(j + k, nBits)) win = 1'b0;
        end
        if (win) vt[j + runLen - 1] = 1'b1;
        bal = win && !odd;
      end
      mark = ao || (nrz && (bal || isOne || isV));
      if (mark) begin
        bit pos = (isV && !ao) ? lastPos : !lastPos;
        ep = pos; en = !pos;
        lastPos = pos;
        odd = (nrz && isV && !ao) ? 1'b0 : !odd;
      end else if (!nrz && j >= 0 && j < nBits && !aoA[j]) begin
        ep = dA[j]; en = nA[j];
      end else begin
        ep = 1'b0; en = 1'b0;
      end
      check(tag, c, actP[c], actN[c], ep, en);
    end
  endtask

  task automatic runSeg(input string tag, input bit nrz, b3, fall, input int nBits);
    int nCyc = nBits + 6;
    @(posedge clk); #2;
    rstN = 1'b0; nrzMode = nrz; b3zsSel = b3; fallEdge = fall;
    allOnes = 1'b0; dataPos = 1'b0; dataNeg = 1'b0;
    repeat (3) begin
      @(posedge clk); #1;
      // R10 rails held low during reset
      check("R10 reset", -1, railPos, railNeg, 1'b0, 1'b0);
    end
    for (int i = 0; i <= nCyc; i++) begin
      bit rp = (i < nBits) ? dA[i] : 1'b0;
      bit rn = (i < nBits) ? nA[i] : 1'b0;
      @(posedge clk); #1;
      if (i > 0) begin actP[i-1] = railPos; actN[i-1] = railNeg; end
      #1;
      if (i == 0) rstN = 1'b1;
      allOnes = (i < nBits) ? aoA[i] : 1'b0;
      dataPos = fall ? rp : !rp;
      dataNeg = fall ? rn : !rn;
      #5;
      dataPos = fall ? !rp : rp;
      dataNeg = fall ? !rn : rn;
    end
    judge(tag, nrz, b3, nBits, nCyc);
  endtask

  task automatic clearArrays();
    for (int k = 0; k < MAXN; k++) begin dA[k] = 0; nA[k] = 0; aoA[k] = 0; end
  endtask

  initial begin
    logic [47:0] patH, patB;
    void'($urandom(32'd4242));
    patH = 48'b0000_0000_0011_0000_1000_0000_1100_0011_0000_0000_0000_0001;
    patB = 48'b0000_0000_0100_0110_0001_0001_0000_0001_1000_0000_0100_0001;

    // R2 R3 R4 R5 R10 R11: directed four-zero runs, first mark positive
    clearArrays();
    for (int k = 0; k < 48; k++) dA[k] = patH[k];
    runSeg("R2/R3/R4/R5/R10/R11 hdb3 directed", 1'b1, 1'b0, 1'b0, 48);

    // R1 R3 R5: directed three-zero runs
    clearArrays();
    for (int k = 0; k < 48; k++) dA[k] = patB[k];
    runSeg("R1/R3/R5 b3zs directed", 1'b1, 1'b1, 1'b0, 48);

    // R2 R7 R8: sparse random data, noisy negative input, falling edge
    clearArrays();
    for (int k = 0; k < 120; k++) begin dA[k] = ($urandom % 4) == 0; nA[k] = $urandom % 2; end
    runSeg("R2/R7/R8 hdb3 random falling", 1'b1, 1'b0, 1'b1, 120);

    // R1 R7 R8: sparse random data, three-zero code, falling edge
    clearArrays();
    for (int k = 0; k < 120; k++) begin dA[k] = ($urandom % 5) == 0; nA[k] = $urandom % 2; end
    runSeg("R1/R7/R8 b3zs random falling", 1'b1, 1'b1, 1'b1, 120);

    // R6 R5: rail format pass-through, rising edge
    clearArrays();
    for (int k = 0; k < 100; k++) begin dA[k] = $urandom % 2; nA[k] = $urandom % 2; end
    runSeg("R6/R5 rail rising", 1'b0, 1'b0, 1'b0, 100);

    // R6 R8: rail format pass-through, falling edge
    clearArrays();
    for (int k = 0; k < 100; k++) begin dA[k] = $urandom % 2; nA[k] = $urandom % 2; end
    runSeg("R6/R8 rail falling", 1'b0, 1'b1, 1'b1, 100);

    // R9 R2 R3: all-ones bursts over sparse NRZ data (override meets substitution)
    clearArrays();
    for (int k = 0; k < 140; k++) begin
      dA[k]  = ($urandom % 6) == 0;
      aoA[k] = ((k / 9) % 3) == 1;
    end
    runSeg("R9/R2/R3 hdb3 all-ones bursts", 1'b1, 1'b0, 1'b0, 140);

    // R9 R1: all-ones bursts with the three-zero code, falling edge
    clearArrays();
    for (int k = 0; k < 140; k++) begin
      dA[k]  = ($urandom % 3) == 0;
      aoA[k] = ($urandom % 8) < 3;
    end
    runSeg("R9/R1 b3zs all-ones random", 1'b1, 1'b1, 1'b1, 140);

    // R9 R6: all-ones in rail format
    clearArrays();
    for (int k = 0; k < 80; k++) begin
      dA[k] = $urandom % 2; nA[k] = $urandom % 2;
      aoA[k] = (k >= 20 && k < 35) || (k == 50);
    end
    runSeg("R9/R6 rail all-ones", 1'b0, 1'b0, 1'b0, 80);

    // R10: all-zero data after reset, empty pipeline sends spaces first
    clearArrays();
    runSeg("R10/R2 zeros after reset", 1'b1, 1'b0, 1'b0, 30);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R5 watchdog act=running exp=done");
      report();
      $finish;
    end
  end

endmodule